// File: doc/BRIEF.md
# SHA-512 Schedule Update-1 Execution Unit

This unit executes one vector instruction: the second message-schedule update step of SHA-512, applied to two independent 64-bit lanes of a 128-bit vector. An instruction word arrives with a valid strobe. The unit matches the word against one fixed opcode pattern and extracts three 5-bit register indices. In the same cycle it reads three 128-bit operands from a 32-entry register file that it holds internally. For each lane it computes the accumulator (the destination's old value) plus the small-sigma-1 of the first source plus the second source.

The result goes into a single output register stage that has a valid/ready handshake. When the consumer accepts the result, it is written back to the destination register. Words that fail the pattern match raise a one-cycle illegal flag and cause no write. A debug write port lets a host preload any register while no instruction is in flight.

Top module: `sched_sig1_unit`

## Requirements
- R1: For each 64-bit lane of the first source, sigma = ROR(x,19) XOR ROR(x,61) XOR (x >> 6), where the shift fills the top six bits with zeros. For example, x = 1 gives 0x0000200000000008.
- R2: Each result lane equals the destination's old lane plus sigma of the first-source lane plus the second-source lane, modulo 2^64. The whole 128-bit result replaces the destination register.
- R3: The lane in bits 127:64 and the lane in bits 63:0 are computed with no carry or data passing between them.
- R4: A word is legal only when bits 31:21 = 11001110011, bit 15 = 1, bit 14 = 0, bits 13:12 = 00 and bits 11:10 = 10 (base word 0xCE608800). The second-source index is bits 20:16, the first-source index is bits 9:5 and the destination index is bits 4:0. out_dst shows the destination index.
- R5: An accepted word that fails the match raises `illegal` for exactly the following cycle. It does not load the output stage and writes no register.
- R6: `in_ready` is high when the output stage is empty or is being accepted. A legal word accepted at one edge appears with `out_valid` high after that edge. A result held while `out_ready` is low keeps its data and index unchanged.
- R7: A result is written back in the cycle its output stage is accepted. An instruction issued in that same cycle sees the newly written value.
- R8: When the destination index equals a source index, every operand read in that instruction uses the value from before the write.
- R9: With `dbg_we` high, `dbg_data` is written into register `dbg_idx` at the clock edge.
- R10: After reset, `out_valid` and `illegal` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Output stage holds a result |
| out_ready | input | 1 | Consumer accepts the result (write-back happens) |
| out_data | output | 128 | Result vector |
| out_dst | output | 5 | Destination register index of the result |
| illegal | output | 1 | One-cycle flag for an unmatched word |
| dbg_we | input | 1 | Debug register write enable |
| dbg_idx | input | 5 | Debug write register index |
| dbg_data | input | 128 | Debug write data |

## Verification
The arithmetic is tried with a single set bit, which isolates each rotate and the shift. It is also tried with an all-ones lower lane plus one, which shows whether a carry leaks into the upper lane, and with random 128-bit operands that catch swapped lanes or operand fields.

Words with each fixed opcode bit flipped in turn show whether every bit of the match is decoded. Chains that reuse the previous destination, driven with `out_ready` held high, separate a working same-cycle bypass from a stale read. Instructions whose destination aliases their sources show whether pre-write values are used. A randomly throttled `out_ready` exercises holding a stalled result.

// File: rtl/sched_sig1_pkg.sv
package sched_sig1_pkg;
  localparam int unsigned LANE_W  = 64;
  localparam int unsigned LANES   = 2;
  localparam int unsigned VEC_W   = LANE_W * LANES;
  localparam int unsigned REG_CNT = 32;
  localparam int unsigned IDX_W   = $clog2(REG_CNT);
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned RD_PORTS = 3;

  // fixed-bit match: bits 31:21 and 15:10
  localparam logic [INSN_W-1:0] OPC_MASK  = 32'hFFE0_FC00;
  localparam logic [INSN_W-1:0] OPC_VALUE = 32'hCE60_8800;

  // operand port numbering
  localparam int unsigned PORT_ACC = 0;
  localparam int unsigned PORT_X   = 1;
  localparam int unsigned PORT_Y   = 2;

  typedef logic [IDX_W-1:0]  reg_idx_t;
  typedef logic [VEC_W-1:0]  vec_t;
  typedef logic [LANE_W-1:0] lane_t;

  function automatic lane_t small_sigma1(input lane_t x);
    lane_t r19, r61, s6;
    r19 = {x[18:0], x[63:19]};
    r61 = {x[60:0], x[63:61]};
    s6  = {6'b0, x[63:6]};
    return r19 ^ r61 ^ s6;
  endfunction

  function automatic lane_t lane_step(input lane_t acc, input lane_t x, input lane_t y);
    return acc + small_sigma1(x) + y;
  endfunction
endpackage

// File: rtl/sig1_decode.sv
module sig1_decode
  import sched_sig1_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output logic              match,
  output reg_idx_t          idx_d,
  output reg_idx_t          idx_n,
  output reg_idx_t          idx_m
);
  assign match = (word & OPC_MASK) == OPC_VALUE;
  assign idx_m = word[20:16];
  assign idx_n = word[9:5];
  assign idx_d = word[4:0];
endmodule

// File: rtl/sig1_regfile.sv
module sig1_regfile #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 128,
  parameter int unsigned PORTS = 3,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    rd_idx  [PORTS],
  output logic [WIDTH-1:0] rd_data [PORTS],
  input  logic             wb_we,
  input  logic [AW-1:0]    wb_idx,
  input  logic [WIDTH-1:0] wb_data,
  input  logic             aux_we,
  input  logic [AW-1:0]    aux_idx,
  input  logic [WIDTH-1:0] aux_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic             wr_en;
  logic [AW-1:0]    wr_idx;
  logic [WIDTH-1:0] wr_data;

  // write-back takes precedence over the auxiliary port
  always_comb begin
    wr_en   = wb_we | aux_we;
    wr_idx  = wb_we ? wb_idx  : aux_idx;
    wr_data = wb_we ? wb_data : aux_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    assign rd_data[p] = mem[rd_idx[p]];
  end
endmodule

// File: rtl/sig1_lane_alu.sv
module sig1_lane_alu
  import sched_sig1_pkg::*;
(
  input  vec_t acc,
  input  vec_t src_x,
  input  vec_t src_y,
  output vec_t res
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign res[l*LANE_W +: LANE_W] =
      lane_step(acc[l*LANE_W +: LANE_W], src_x[l*LANE_W +: LANE_W], src_y[l*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/sched_sig1_unit.sv
module sched_sig1_unit
  import sched_sig1_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [127:0]  out_data,
  output logic [4:0]    out_dst,
  output logic          illegal,
  input  logic          dbg_we,
  input  logic [4:0]    dbg_idx,
  input  logic [127:0]  dbg_data
);
  // named internal events
  logic     dec_match;
  logic     issue_fire;
  logic     issue_ok;
  logic     wb_fire;
  reg_idx_t idx_d, idx_n, idx_m;

  reg_idx_t rd_idx  [RD_PORTS];
  vec_t     rf_data [RD_PORTS];
  vec_t     opnd    [RD_PORTS];
  vec_t     alu_res;

  sig1_decode u_dec (
    .word  (in_word),
    .match (dec_match),
    .idx_d (idx_d),
    .idx_n (idx_n),
    .idx_m (idx_m)
  );

  assign in_ready   = !out_valid || out_ready;
  assign issue_fire = in_valid && in_ready;
  assign issue_ok   = issue_fire && dec_match;
  assign wb_fire    = out_valid && out_ready;

  assign rd_idx[PORT_ACC] = idx_d;
  assign rd_idx[PORT_X]   = idx_n;
  assign rd_idx[PORT_Y]   = idx_m;

  sig1_regfile #(
    .DEPTH (REG_CNT),
    .WIDTH (VEC_W),
    .PORTS (RD_PORTS)
  ) u_rf (
    .clk      (clk),
    .rd_idx   (rd_idx),
    .rd_data  (rf_data),
    .wb_we    (wb_fire),
    .wb_idx   (out_dst),
    .wb_data  (out_data),
    .aux_we   (dbg_we),
    .aux_idx  (dbg_idx),
    .aux_data (dbg_data)
  );

  // bypass the value being written back this cycle
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_byp
    assign opnd[p] = (wb_fire && out_dst == rd_idx[p]) ? out_data : rf_data[p];
  end

  sig1_lane_alu u_alu (
    .acc   (opnd[PORT_ACC]),
    .src_x (opnd[PORT_X]),
    .src_y (opnd[PORT_Y]),
    .res   (alu_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      illegal <= issue_fire && !dec_match;
      if (issue_ok)       out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (issue_ok) begin
      out_data <= alu_res;
      out_dst  <= idx_d;
    end
  end
endmodule

// File: rtl/sched_sig1_chk.sv
module sched_sig1_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [31:0]  in_word,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_data,
  input logic [4:0]   out_dst,
  input logic         illegal,
  input logic         dec_match,
  input logic         issue_fire,
  input logic         wb_fire
);
  // R6: a stalled result is held unchanged
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_dst));

  // R4: destination field reaches out_dst
  p_dst_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire && dec_match |=> out_valid && out_dst == $past(in_word[4:0]));

  // R5: an unmatched word never loads the output stage
  p_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire && !dec_match |=> !out_valid);

  // R5: illegal only follows an accepted unmatched word
  p_ill_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(issue_fire && !dec_match));

  // R7: after write-back the stage is empty unless refilled
  p_wb_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> !out_valid || $past(issue_fire));
endmodule

bind sched_sig1_unit sched_sig1_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_word    (in_word),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_dst    (out_dst),
  .illegal    (illegal),
  .dec_match  (dec_match),
  .issue_fire (issue_fire),
  .wb_fire    (wb_fire)
);

// File: tb/sim_sched_sig1_unit.sv
`timescale 1ns/1ps
module sim_sched_sig1_unit;
  localparam real CLK_PER = 8.0;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_word = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic [4:0]   out_dst;
  logic         illegal;
  logic         dbg_we = 1'b0;
  logic [4:0]   dbg_idx = '0;
  logic [127:0] dbg_data = '0;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit rnd_mode = 1'b0;
  bit done = 1'b0;
  string phase = "R2";

  always #(CLK_PER/2) clk = ~clk;

  sched_sig1_unit u0 (.*);

  // ---------------- reference model ----------------
  logic [127:0] mrf [32];
  logic         m_ov = 1'b0, m_ill = 1'b0;
  logic [127:0] m_data = '0;
  logic [4:0]   m_dst = '0;

  function automatic logic [63:0] ref_s1(input logic [63:0] v);
    return ((v >> 19) | (v << 45)) ^ ((v >> 61) | (v << 3)) ^ (v >> 6);
  endfunction

  function automatic bit ref_legal(input logic [31:0] w);
    return w[31:21] == 11'b11001110011 && w[15] && !w[14] && w[13:12] == 2'b00 && w[11:10] == 2'b10;
  endfunction

  function automatic logic [31:0] mk(input int d, input int n, input int m);
    return 32'hCE608800 | (32'(m) << 16) | (32'(n) << 5) | 32'(d);
  endfunction

  always @(posedge clk) begin
    logic rdy, fire, ok, wb;
    logic [127:0] a, x, y;
    if (!rst_n) begin
      m_ov = 1'b0; m_ill = 1'b0;
    end else begin
      rdy  = !m_ov || out_ready;
      fire = in_valid && rdy;
      ok   = fire && ref_legal(in_word);
      wb   = m_ov && out_ready;
      a = (wb && m_dst == in_word[4:0])   ? m_data : mrf[in_word[4:0]];
      x = (wb && m_dst == in_word[9:5])   ? m_data : mrf[in_word[9:5]];
      y = (wb && m_dst == in_word[20:16]) ? m_data : mrf[in_word[20:16]];
      if (dbg_we) mrf[dbg_idx] = dbg_data;
      if (wb) mrf[m_dst] = m_data;
      m_ill = fire && !ok;
      if (ok) begin
        m_ov = 1'b1;
        m_data[127:64] = a[127:64] + ref_s1(x[127:64]) + y[127:64];
        m_data[63:0]   = a[63:0]   + ref_s1(x[63:0])   + y[63:0];
        m_dst = in_word[4:0];
      end else if (out_ready) m_ov = 1'b0;
    end
  end

  task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare on every clock, away from both edges
  always @(negedge clk) begin
    #2;
    if (rst_n && cmp_on) begin
      chk("R6", "out_valid", 128'(out_valid), 128'(m_ov));
      chk("R6", "in_ready", 128'(in_ready), 128'(!m_ov || out_ready));
      chk("R5", "illegal", 128'(illegal), 128'(m_ill));
      if (m_ov) begin
        chk(phase, "out_data", out_data, m_data);
        chk("R4", "out_dst", 128'(out_dst), 128'(m_dst));
      end
    end
  end

  always @(negedge clk) out_ready = rnd_mode ? 1'($urandom_range(0, 1)) : 1'b1;

  // ---------------- stimulus tasks ----------------
  task automatic issue(input logic [31:0] w);
    in_valid = 1'b1; in_word = w;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (out_valid) @(negedge clk);
  endtask

  task automatic load(input int idx, input logic [127:0] v);
    dbg_we = 1'b1; dbg_idx = 5'(idx); dbg_data = v;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R10", "out_valid after reset", 128'(out_valid), 128'(0));
    chk("R10", "illegal after reset", 128'(illegal), 128'(0));
    chk("R10", "in_ready after reset", 128'(in_ready), 128'(1));
    @(negedge clk);
    cmp_on = 1'b1;

    phase = "R9";
    for (int i = 0; i < 32; i++)
      load(i, {64'h0123_4567_89AB_CDEF * 64'(i + 3), 64'hFEDC_BA98_7654_3210 ^ 64'(i * 977)});

    // R1: single set bit isolates rotates and shift
    phase = "R1";
    load(4, '0); load(5, {64'h1, 64'h1}); load(6, '0);
    issue(mk(4, 5, 6)); #2;
    chk("R1", "sigma of one", out_data, {2{64'h0000_2000_0000_0008}});
    @(negedge clk);

    // R3: lower lane wraps without carrying into the upper lane
    phase = "R3";
    load(7, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}); load(8, '0); load(9, {64'h0, 64'h1});
    issue(mk(7, 8, 9)); #2;
    chk("R3", "lane isolation", out_data, 128'h0);
    @(negedge clk);

    // R4: varied register fields
    phase = "R4";
    issue(mk(31, 0, 17)); issue(mk(1, 30, 2)); issue(mk(16, 16, 0));
    drain();

    // R5: flip each fixed opcode bit in turn
    phase = "R5";
    for (int b = 10; b < 32; b++)
      if (b < 16 || b > 20) issue(mk(3, 12, 13) ^ (32'h1 << b));
    drain();
    // reading r3 shows it was never written by those words
    issue(mk(20, 3, 3)); drain();

    // R7: dependent back-to-back chain, always accepted
    phase = "R7";
    for (int i = 0; i < 6; i++) issue(mk(10, 10, 11));
    for (int i = 0; i < 4; i++) issue(mk(12, 10, 12));
    drain();

    // R8: destination aliasing sources
    phase = "R8";
    issue(mk(14, 14, 14)); issue(mk(15, 15, 2)); issue(mk(2, 9, 2));
    drain();

    // R9: debug write observed through an instruction
    phase = "R9";
    load(21, 128'h0); load(22, '0); load(23, 128'hDEAD_BEEF_0000_0001_CAFE_F00D_1234_5678);
    issue(mk(21, 22, 23)); #2;
    chk("R9", "debug value read back", out_data, 128'hDEAD_BEEF_0000_0001_CAFE_F00D_1234_5678);
    @(negedge clk);
    drain();

    // R2 / R6: random stream with throttled consumer
    phase = "R2";
    rnd_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      w = mk($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31));
      if ($urandom_range(0, 5) == 0) w ^= 32'h1 << (($urandom_range(0, 1) == 1) ? $urandom_range(21, 31) : $urandom_range(10, 15));
      issue(w);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    rnd_mode = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule